// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutation Decoder

This block drives a three-phase half-H bridge from three Hall position bits and a rotation-direction bit. It resynchronises and debounces the Hall bits, maps the filtered code to one of six commutation steps, and raises one upper and one lower gate enable on two different phases. The upper switch of the energised pair is chopped by an incoming PWM carrier. The lower switch stays fully on for the whole step.

A peak-current comparator flag ends the upper on-time for the rest of the current PWM period. After each PWM rising edge the flag is ignored for a blanking window, so the turn-on spike is not taken as winding current. The two codes that no sensor position can produce turn off every switch and raise a fault flag. Every enable passes through a per-phase dead-time stage, so the two switches of a phase never conduct together.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_ccw`=0, the filtered Hall code {hall_in[2],hall_in[1],hall_in[0]} selects the drive pattern `hs_en`/`ls_en` (bit 0 = phase A, bit 1 = B, bit 2 = C) as follows. 001 gives A-high/B-low, 011 gives A-high/C-low, 010 gives B-high/C-low, 110 gives B-high/A-low, 100 gives C-high/A-low, 101 gives C-high/B-low.
- R2: With `dir_ccw`=1, the bitwise complement of each code in R1 selects the same drive pattern: 110, 100, 101, 001, 011, 010 map to the six patterns in the order R1 lists them.
- R3: While the filtered code is 000 or 111, all six enables are low and `hall_fault` is high. `hall_fault` is low while the code is legal.
- R4: The upper enable of the energised phase follows `pwm_in`. The lower enable stays high whatever `pwm_in` does.
- R5: A current trip that is accepted holds the upper enable low until the next rising edge of `pwm_in`. The lower enable is not affected.
- R6: `ilim_trip` has no effect during the BLANK_CLKS (default 8) clocks after each rising edge of `pwm_in`.
- R7: A Hall change takes effect only after three consecutive synchronised samples agree. A change that lasts two clocks is ignored.
- R8: The upper and lower enables of one phase are never high together. When a phase swaps sides, the new enable rises DEAD_CLKS+1 (default 3) clocks after the old one falls.
- R9: During reset and until a filtered Hall code exists, all enables and `hall_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Hall position bits, bit 2 is the first sensor |
| dir_ccw | input | 1 | Direction: 0 clockwise, 1 counter-clockwise |
| pwm_in | input | 1 | PWM carrier for the upper switches |
| ilim_trip | input | 1 | Peak-current comparator flag |
| hs_en | output | 3 | Upper gate enables, bit 0 = phase A |
| ls_en | output | 3 | Lower gate enables, bit 0 = phase A |
| hall_fault | output | 1 | High while the filtered Hall code is illegal |

## Verification
The assertions assume that `pwm_in`, `ilim_trip` and `dir_ccw` are already synchronous to `clk`; only the Hall bits may change without regard to the clock. They also assume that reset is asserted from time zero. The stimulus drives every input on the falling clock edge and changes `dir_ccw` only together with a new Hall code. Each pattern is held long enough for the synchroniser, the filter and the dead time to settle before the outputs are sampled.

// File: rtl/hall_commute_pkg.sv
package hall_commute_pkg;

    localparam int NPH = 3;

    typedef enum logic [2:0] {
        STEP_A, STEP_B, STEP_C, STEP_D, STEP_E, STEP_F, STEP_OFF
    } step_e;

    typedef struct packed {
        logic [NPH-1:0] hi;
        logic [NPH-1:0] lo;
    } drive_t;

    function automatic logic code_illegal(logic [2:0] code);
        return (code == 3'b000) || (code == 3'b111);
    endfunction

    // reverse rotation reads the complemented code
    function automatic step_e hall_to_step(logic [2:0] code, logic ccw);
        logic [2:0] c;
        c = ccw ? ~code : code;
        case (c)
            3'b001:  return STEP_A;
            3'b011:  return STEP_B;
            3'b010:  return STEP_C;
            3'b110:  return STEP_D;
            3'b100:  return STEP_E;
            3'b101:  return STEP_F;
            default: return STEP_OFF;
        endcase
    endfunction

    function automatic drive_t step_to_drive(step_e s);
        drive_t d;
        case (s)
            STEP_A:  d = '{hi: 3'b001, lo: 3'b010};
            STEP_B:  d = '{hi: 3'b001, lo: 3'b100};
            STEP_C:  d = '{hi: 3'b010, lo: 3'b100};
            STEP_D:  d = '{hi: 3'b010, lo: 3'b001};
            STEP_E:  d = '{hi: 3'b100, lo: 3'b001};
            STEP_F:  d = '{hi: 3'b100, lo: 3'b010};
            default: d = '{hi: 3'b000, lo: 3'b000};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/hall_filter.sv
module hall_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_raw,
    output logic [2:0] code_q,
    output logic       valid_q
);
    localparam int FILL = SYNC_STAGES + FILT_DEPTH;

    logic [2:0]      sync_r [SYNC_STAGES];
    logic [2:0]      hist_r [FILT_DEPTH];
    logic [FILL-1:0] fill_r;
    logic            all_eq;

    always_comb begin
        all_eq = 1'b1;
        for (int i = 1; i < FILT_DEPTH; i++)
            if (hist_r[i] != hist_r[0]) all_eq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) sync_r[i] <= '0;
            for (int i = 0; i < FILT_DEPTH; i++)  hist_r[i] <= '0;
            fill_r  <= '0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            sync_r[0] <= hall_raw;
            for (int i = 1; i < SYNC_STAGES; i++) sync_r[i] <= sync_r[i-1];
            hist_r[0] <= sync_r[SYNC_STAGES-1];
            for (int i = 1; i < FILT_DEPTH; i++) hist_r[i] <= hist_r[i-1];
            fill_r <= {fill_r[FILL-2:0], 1'b1};
            if (fill_r[FILL-1] && all_eq) begin
                code_q  <= hist_r[0];
                valid_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ilim_blank.sv
module ilim_blank #(
    parameter int BLANK_CLKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm,
    input  logic trip,
    output logic hs_allow,
    output logic trip_held
);
    localparam int CW = $clog2(BLANK_CLKS + 1);

    logic          pwm_q;
    logic          pwm_rise;
    logic [CW-1:0] blank_cnt;

    assign pwm_rise = pwm && !pwm_q;
    assign hs_allow = pwm && !trip_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q     <= 1'b0;
            blank_cnt <= '0;
            trip_held <= 1'b0;
        end else begin
            pwm_q <= pwm;
            if (pwm_rise) begin
                blank_cnt <= CW'(BLANK_CLKS);
                trip_held <= 1'b0;
            end else begin
                if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
                else if (trip)       trip_held <= 1'b1;
            end
        end
    end

    // R6: a new PWM period always starts with the trip released
    p_blank_release_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm) |=> !trip_held);

    // R5: a held trip was caused by the comparator flag
    p_trip_source_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_held) |-> $past(trip));
endmodule

// File: rtl/phase_deadtime.sv
module phase_deadtime #(
    parameter int DEAD_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_hi,
    input  logic req_lo,
    output logic en_hi,
    output logic en_lo
);
    localparam int CW = $clog2(DEAD_CLKS + 1);
    localparam logic [CW-1:0] IDLE_MAX = CW'(DEAD_CLKS);

    logic [CW-1:0] idle_cnt;
    logic          idle_done;

    assign idle_done = (idle_cnt == IDLE_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
            en_hi    <= 1'b0;
            en_lo    <= 1'b0;
        end else begin
            if (en_hi || en_lo)  idle_cnt <= '0;
            else if (!idle_done) idle_cnt <= idle_cnt + 1'b1;
            en_hi <= req_hi && !req_lo && (en_hi || (idle_done && !en_lo));
            en_lo <= req_lo && !req_hi && (en_lo || (idle_done && !en_hi));
        end
    end

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(en_hi && en_lo));

    p_dead_lo_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(en_lo) |-> (!$past(en_hi) && !$past(en_hi, 2)));

    p_dead_hi_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(en_hi) |-> (!$past(en_lo) && !$past(en_lo, 2)));
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_commute_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_DEPTH  = 3,
    parameter int BLANK_CLKS  = 8,
    parameter int DEAD_CLKS   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     hall_in,
    input  logic           dir_ccw,
    input  logic           pwm_in,
    input  logic           ilim_trip,
    output logic [NPH-1:0] hs_en,
    output logic [NPH-1:0] ls_en,
    output logic           hall_fault
);
    logic [2:0] code;
    logic       code_valid;
    logic       hs_allow;
    logic       trip_held;
    drive_t     drive;
    logic [NPH-1:0] req_hi;

    hall_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_DEPTH(FILT_DEPTH)) u_filter (
        .clk(clk), .rst(rst), .hall_raw(hall_in),
        .code_q(code), .valid_q(code_valid)
    );

    ilim_blank #(.BLANK_CLKS(BLANK_CLKS)) u_ilim (
        .clk(clk), .rst(rst), .pwm(pwm_in), .trip(ilim_trip),
        .hs_allow(hs_allow), .trip_held(trip_held)
    );

    always_comb begin
        drive = '{hi: '0, lo: '0};
        if (code_valid) drive = step_to_drive(hall_to_step(code, dir_ccw));
    end

    assign hall_fault = code_valid && code_illegal(code);
    assign req_hi     = drive.hi & {NPH{hs_allow}};

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        phase_deadtime #(.DEAD_CLKS(DEAD_CLKS)) u_dt (
            .clk(clk), .rst(rst),
            .req_hi(req_hi[p]), .req_lo(drive.lo[p]),
            .en_hi(hs_en[p]), .en_lo(ls_en[p])
        );
    end

    p_fault_off_r3: assert property (@(posedge clk) disable iff (rst)
        hall_fault |=> (hs_en == '0 && ls_en == '0));

    p_trip_hs_r5: assert property (@(posedge clk) disable iff (rst)
        trip_held |=> (hs_en == '0));

    p_pair_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hs_en) && $onehot0(ls_en) && ((hs_en & ls_en) == '0));
endmodule

// File: tb/hall_commutator_bench.sv
module hall_commutator_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b000;
    logic       dir_ccw = 1'b0;
    logic       pwm_in = 1'b1;
    logic       ilim_trip = 1'b0;
    logic [2:0] hs_en, ls_en;
    logic       hall_fault;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hall_commutator u_hall_commutator (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_ccw(dir_ccw),
        .pwm_in(pwm_in), .ilim_trip(ilim_trip),
        .hs_en(hs_en), .ls_en(ls_en), .hall_fault(hall_fault)
    );

    // {dir, hall[2:0], hi[2:0], lo[2:0], fault}
    localparam logic [10:0] VEC [14] = '{
        {1'b0, 3'b001, 3'b001, 3'b010, 1'b0},
        {1'b0, 3'b011, 3'b001, 3'b100, 1'b0},
        {1'b0, 3'b010, 3'b010, 3'b100, 1'b0},
        {1'b0, 3'b110, 3'b010, 3'b001, 1'b0},
        {1'b0, 3'b100, 3'b100, 3'b001, 1'b0},
        {1'b0, 3'b101, 3'b100, 3'b010, 1'b0},
        {1'b1, 3'b110, 3'b001, 3'b010, 1'b0},
        {1'b1, 3'b100, 3'b001, 3'b100, 1'b0},
        {1'b1, 3'b101, 3'b010, 3'b100, 1'b0},
        {1'b1, 3'b001, 3'b010, 3'b001, 1'b0},
        {1'b1, 3'b011, 3'b100, 3'b001, 1'b0},
        {1'b1, 3'b010, 3'b100, 3'b010, 1'b0},
        {1'b0, 3'b000, 3'b000, 3'b000, 1'b1},
        {1'b1, 3'b111, 3'b000, 3'b000, 1'b1}
    };

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t_off, t_on, same_err;
        logic seen;
        logic [6:0] ref_out;

        // R9: reset and fill state
        wait_n(3);
        chk("R9 reset", {hs_en, ls_en, hall_fault}, 7'b0);
        hall_in = 3'b001;
        rst = 1'b0;
        wait_n(2);
        chk("R9 before filter fills", {hs_en, ls_en, hall_fault}, 7'b0);

        // R1 R2 R3: table walk
        for (int i = 0; i < 14; i++) begin
            dir_ccw = VEC[i][10];
            hall_in = VEC[i][9:7];
            wait_n(16);
            chk(VEC[i][0] ? "R3 illegal code" : (VEC[i][10] ? "R2 reverse step" : "R1 forward step"),
                {hs_en, ls_en, hall_fault}, VEC[i][6:0]);
        end

        // R3: fault persists and clears
        hall_in = 3'b111; dir_ccw = 1'b0;
        wait_n(12);
        same_err = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!hall_fault || hs_en != 0 || ls_en != 0) same_err++;
        end
        chk("R3 fault persists", same_err, 0);
        hall_in = 3'b001;
        wait_n(16);
        chk("R3 fault clears", {hs_en, ls_en, hall_fault}, {3'b001, 3'b010, 1'b0});

        // R4: chopping only on the upper switch
        pwm_in = 1'b0;
        wait_n(3);
        chk("R4 pwm low", {hs_en, ls_en}, {3'b000, 3'b010});
        pwm_in = 1'b1;
        wait_n(3);
        chk("R4 pwm high", {hs_en, ls_en}, {3'b001, 3'b010});

        // R6: trip in blanking window ignored
        pwm_in = 1'b0;
        wait_n(4);
        pwm_in = 1'b1; ilim_trip = 1'b1;
        wait_n(5);
        ilim_trip = 1'b0;
        wait_n(3);
        chk("R6 blanked trip", hs_en, 3'b001);

        // R5: accepted trip holds until next rise
        wait_n(10);
        ilim_trip = 1'b1;
        wait_n(1);
        ilim_trip = 1'b0;
        wait_n(3);
        chk("R5 trip cuts upper", {hs_en, ls_en}, {3'b000, 3'b010});
        wait_n(10);
        chk("R5 trip held", {hs_en, ls_en}, {3'b000, 3'b010});
        pwm_in = 1'b0;
        wait_n(4);
        pwm_in = 1'b1;
        wait_n(4);
        chk("R5 released on rise", {hs_en, ls_en}, {3'b001, 3'b010});

        // R7: two-clock glitch ignored
        ref_out = {hs_en, ls_en, hall_fault};
        hall_in = 3'b011;
        wait_n(2);
        hall_in = 3'b001;
        same_err = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if ({hs_en, ls_en, hall_fault} != ref_out) same_err++;
        end
        chk("R7 glitch ignored", same_err, 0);

        // R7: three-clock pulse accepted
        hall_in = 3'b011;
        wait_n(3);
        hall_in = 3'b001;
        seen = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (ls_en == 3'b100) seen = 1'b1;
        end
        chk("R7 three samples accepted", seen, 1'b1);
        wait_n(10);

        // R8: phase A swaps from upper to lower
        t_off = -1; t_on = -1;
        hall_in = 3'b110;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (t_off < 0 && hs_en[0] == 1'b0) t_off = i;
            if (t_on < 0 && ls_en[0] == 1'b1) t_on = i;
        end
        chk("R8 dead time", t_on - t_off, 3);
        chk("R8 final step", {hs_en, ls_en}, {3'b010, 3'b001});

        summary();
        $finish;
    end
endmodule